// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block turns a virtual address into a physical address by reading one entry from a flat page table in memory. A requester presents a virtual address and an access kind: load, store or instruction fetch. The block splits the address into a virtual page number and a page offset. It computes the entry address from a base register plus four times the page number, and issues one read on a simple memory read port. It then waits however long the memory needs before the read-valid strobe arrives.

The returned 32-bit entry is decoded into a present bit, three permission bits and a physical page number. The response carries either the translated physical address with status OK, or a zero address with one of two fault codes. A non-present page gives a page-miss fault. An access the entry does not permit gives a permission fault.

The block handles one translation at a time. Software loads the base register through a write strobe, and the block accepts that write only while it is idle. Address widths and page size are parameters, with defaults of a 48-bit virtual address, a 34-bit physical address and 16 KiB pages.

Top module: `pt_xlate`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, and both `rsp_valid` and `mem_rd_en` are 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), `mem_rd_en` is high for exactly one cycle. `mem_rd_addr` then equals the base register plus the virtual page number (`req_vaddr[VA_W-1:PG_BITS]`) times 4, modulo 2^PA_W.
- R3: Entry layout: bit 0 is present, bit 1 allows loads, bit 2 allows stores, bit 3 allows fetches, and bits 23:4 hold the physical page number. A permitted access responds with status 2'b00 and `rsp_paddr` = {page number, `req_vaddr[PG_BITS-1:0]`}.
- R4: An entry with bit 0 clear responds with status 2'b01 and `rsp_paddr` = 0, whatever its permission bits and the access kind.
- R5: Access kinds are 2'b00 load, 2'b01 store and 2'b10 fetch. Each needs its own permission bit, and kind 2'b11 is never permitted. A present entry that lacks the needed permission responds with status 2'b10 and `rsp_paddr` = 0.
- R6: From acceptance until the response is taken, `req_ready` is 0. A request presented during that time is not accepted and does not change the pending response.
- R7: The response appears once the read-valid strobe has been seen. While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its fields hold steady. Taking the response returns the block to idle in the next cycle.
- R8: The block waits any number of cycles for `mem_rd_valid`. A strobe that arrives while no read is outstanding is ignored.
- R9: A base-register write (`base_we`) takes effect only while the block is idle. A write while a translation is in flight is dropped.
- R10: The response status is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | PA_W | New page table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| mem_rd_en | output | 1 | One-cycle read request for the table entry |
| mem_rd_addr | output | PA_W | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Table entry contents |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | PA_W | Translated physical address, zero on a fault |
| rsp_status | output | 2 | 00 OK, 01 page miss, 10 permission fault |

## Verification
The bench targets an entry that grants every permission but has its present bit clear. A design that checks permissions first would return OK or a permission fault there, not a page miss. It also uses the all-ones page number, where the scaled index wraps. A design that drops the carry or shifts by the wrong amount would fetch the wrong entry, and the bench sees the bad read address. The bench also sends read-valid strobes while idle, writes the base and issues a second request while a walk is in flight, and stalls the response. A block that reacts to any of these would start a spurious response, move a later walk's address, or change the pending result.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;

  localparam logic [1:0] KIND_LOAD  = 2'b00;
  localparam logic [1:0] KIND_STORE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  localparam logic [1:0] STS_OK    = 2'b00;
  localparam logic [1:0] STS_NOMAP = 2'b01;
  localparam logic [1:0] STS_DENY  = 2'b10;

  localparam int ENT_W     = 32;
  localparam int BIT_PRES  = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_WR    = 2;
  localparam int BIT_EX    = 3;
  localparam int PPN_LSB   = 4;
  localparam int IDX_SHIFT = 2;

endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_xlate_pkg::*;
#(
  parameter int PPN_W = 20
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       kind,
  output logic [PPN_W-1:0] ppn,
  output logic [1:0]       status
);
  logic allowed;

  assign ppn = entry[PPN_LSB +: PPN_W];

  always_comb begin
    unique case (kind)
      KIND_LOAD:  allowed = entry[BIT_RD];
      KIND_STORE: allowed = entry[BIT_WR];
      KIND_FETCH: allowed = entry[BIT_EX];
      default:    allowed = 1'b0;
    endcase
  end

  // a missing page outranks any permission result
  always_comb begin
    if (!entry[BIT_PRES])  status = STS_NOMAP;
    else if (!allowed)     status = STS_DENY;
    else                   status = STS_OK;
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_valid,
  input  logic rsp_ready,
  output logic idle,
  output logic accept,
  output logic rd_issue,
  output logic capture,
  output logic rsp_valid
);
  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid)    st_d = ST_FETCH;
      ST_FETCH:                   st_d = ST_WAIT;
      ST_WAIT:  if (mem_rd_valid) st_d = ST_RESP;
      ST_RESP:  if (rsp_ready)    st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle      = (st_q == ST_IDLE);
  assign accept    = idle && req_valid;
  assign rd_issue  = (st_q == ST_FETCH);
  assign capture   = (st_q == ST_WAIT) && mem_rd_valid;
  assign rsp_valid = (st_q == ST_RESP);
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 34,
  parameter int PG_BITS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_status
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PPN_W = PA_W - PG_BITS;
  localparam int IDX_W = VPN_W + IDX_SHIFT;

  logic              rst_sync_n;
  logic              idle, accept, rd_issue, capture;
  logic [PA_W-1:0]   base_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        kind_q;
  logic [PA_W-1:0]   pa_q;
  logic [1:0]        sts_q;
  logic [PPN_W-1:0]  ent_ppn;
  logic [1:0]        ent_sts;
  logic [IDX_W-1:0]  idx_bytes;

  pt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pt_walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_valid    (req_valid),
    .mem_rd_valid (mem_rd_valid),
    .rsp_ready    (rsp_ready),
    .idle         (idle),
    .accept       (accept),
    .rd_issue     (rd_issue),
    .capture      (capture),
    .rsp_valid    (rsp_valid)
  );

  pt_entry_check #(.PPN_W(PPN_W)) u_chk_ent (
    .entry  (mem_rd_data),
    .kind   (kind_q),
    .ppn    (ent_ppn),
    .status (ent_sts)
  );

  // base register: enable is the idle state
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)          base_q <= '0;
    else if (base_we && idle) base_q <= base_wdata;
  end

  // request capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      va_q   <= '0;
      kind_q <= KIND_LOAD;
    end else if (accept) begin
      va_q   <= req_vaddr;
      kind_q <= req_kind;
    end
  end

  // response capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pa_q  <= '0;
      sts_q <= STS_OK;
    end else if (capture) begin
      sts_q <= ent_sts;
      pa_q  <= (ent_sts == STS_OK) ? {ent_ppn, va_q[PG_BITS-1:0]} : '0;
    end
  end

  assign idx_bytes   = {va_q[VA_W-1:PG_BITS], {IDX_SHIFT{1'b0}}};
  assign mem_rd_addr = base_q + PA_W'(idx_bytes);
  assign mem_rd_en   = rd_issue;
  assign req_ready   = idle;
  assign rsp_paddr   = pa_q;
  assign rsp_status  = sts_q;
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int PA_W    = 34,
  parameter int PG_BITS = 14
) (
  input logic               clk,
  input logic               rst_ok_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               mem_rd_en,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [1:0]         rsp_status,
  input logic [PA_W-1:0]    base_q,
  input logic [PG_BITS-1:0] va_lo
);
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_rd_en |=> !mem_rd_en); // R2
  AST_RD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(mem_rd_en) |-> $past(req_valid && req_ready)); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rsp_valid && rsp_status == 2'b00) |-> rsp_paddr[PG_BITS-1:0] == va_lo); // R3
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rsp_valid && rsp_status != 2'b00) |-> rsp_paddr == '0); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rsp_valid |-> !req_ready); // R6
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status))); // R7
  AST_BASE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !req_ready |=> $stable(base_q)); // R9
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rsp_valid |-> rsp_status != 2'b11); // R10
endmodule

bind pt_xlate pt_xlate_chk #(.PA_W(PA_W), .PG_BITS(PG_BITS)) u_xlate_chk (
  .clk        (clk),
  .rst_ok_n   (rst_sync_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_rd_en  (mem_rd_en),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_status (rsp_status),
  .base_q     (base_q),
  .va_lo      (va_q[PG_BITS-1:0])
);

// File: tb/sim_pt_xlate.sv
`timescale 1ns/1ps
module sim_pt_xlate;
  localparam int VA_W = 48;
  localparam int PA_W = 34;
  localparam int PGB  = 14;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            base_we;
  logic [PA_W-1:0] base_wdata;
  logic            req_valid;
  logic            req_ready;
  logic [VA_W-1:0] req_vaddr;
  logic [1:0]      req_kind;
  logic            mem_rd_en;
  logic [PA_W-1:0] mem_rd_addr;
  logic            mem_rd_valid;
  logic [31:0]     mem_rd_data;
  logic            rsp_valid;
  logic            rsp_ready;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0]      rsp_status;

  int checks = 0;
  int errors = 0;
  logic [PA_W-1:0] base_model;

  always #10 clk = ~clk;

  pt_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PGB)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sts(input logic [31:0] e, input logic [1:0] k);
    logic perm;
    case (k)
      2'b00:   perm = e[1];
      2'b01:   perm = e[2];
      2'b10:   perm = e[3];
      default: perm = 1'b0;
    endcase
    if (!e[0])     return 2'b01;
    else if (!perm) return 2'b10;
    else           return 2'b00;
  endfunction

  function automatic logic [PA_W-1:0] exp_addr(input logic [VA_W-1:0] va);
    logic [VA_W-PGB+1:0] idx;
    idx = {va[VA_W-1:PGB], 2'b00};
    return base_model + idx[PA_W-1:0];
  endfunction

  task automatic set_base(input logic [PA_W-1:0] b);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    base_model = b;
  endtask

  // one full translation; poke drives a base write and a second request mid-walk
  task automatic xlate(input logic [VA_W-1:0] va, input logic [1:0] kind,
                       input logic [31:0] ent, input int lat, input int hold,
                       input bit poke, input string req);
    logic [1:0]      es;
    logic [PA_W-1:0] ea;
    es = exp_sts(ent, kind);
    ea = (es == 2'b00) ? {ent[23:4], va[PGB-1:0]} : '0;
    chk(req_ready == 1'b1, "R6", "ready before request", 64'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_en == 1'b1, "R2", "read strobe", 64'(mem_rd_en), 1);
    chk(mem_rd_addr == exp_addr(va), "R2", "entry address", 64'(mem_rd_addr), 64'(exp_addr(va)));
    chk(req_ready == 1'b0, "R6", "ready while busy", 64'(req_ready), 0);
    @(negedge clk);
    chk(mem_rd_en == 1'b0, "R2", "read strobe one cycle", 64'(mem_rd_en), 0);
    if (poke) begin
      base_we = 1'b1; base_wdata = ~base_model;
      req_valid = 1'b1; req_vaddr = ~va; req_kind = 2'b00;
      @(negedge clk);
      base_we = 1'b0; req_valid = 1'b0;
      chk(req_ready == 1'b0, "R6", "second request not taken", 64'(req_ready), 0);
    end
    for (int i = 0; i < lat; i++) begin
      chk(rsp_valid == 1'b0, "R8", "no response before strobe", 64'(rsp_valid), 0);
      @(negedge clk);
    end
    mem_rd_valid = 1'b1; mem_rd_data = ent;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
    chk(rsp_valid == 1'b1, "R7", "response after strobe", 64'(rsp_valid), 1);
    chk(rsp_status == es, req, "status", 64'(rsp_status), 64'(es));
    chk(rsp_paddr == ea, req, "paddr", 64'(rsp_paddr), 64'(ea));
    chk(rsp_status != 2'b11, "R10", "status legal", 64'(rsp_status), 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_status == es && rsp_paddr == ea, "R7", "held response",
          64'(rsp_paddr), 64'(ea));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R7", "back to idle",
        64'({rsp_valid, req_ready}), 64'(2'b01));
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", 64'(rsp_valid), 0);
    chk(mem_rd_en == 1'b0, "R1", "reset mem_rd_en", 64'(mem_rd_en), 0);
  endtask

  task automatic t_grants();
    set_base(34'h0_1234_5000);
    xlate(48'h0000_0012_3ABC, 2'b00, 32'h00A_BCD3, 0, 0, 0, "R3");
    xlate(48'h7654_3210_0FFF, 2'b01, 32'h001_2345, 2, 0, 0, "R3");
    xlate(48'h0000_8000_1234, 2'b10, 32'h0FF_FFF9, 1, 0, 0, "R3");
  endtask

  task automatic t_miss();
    xlate(48'h0000_0000_4001, 2'b00, 32'h0AA_AAAE, 0, 0, 0, "R4");
    xlate(48'h0000_0000_8002, 2'b10, 32'h055_555E, 3, 0, 0, "R4");
  endtask

  task automatic t_deny();
    xlate(48'h0000_0001_0000, 2'b01, 32'h012_340B, 0, 0, 0, "R5");
    xlate(48'h0000_0001_4000, 2'b10, 32'h012_3407, 0, 0, 0, "R5");
    xlate(48'h0000_0001_8000, 2'b00, 32'h012_340D, 0, 0, 0, "R5");
    xlate(48'h0000_0001_C000, 2'b11, 32'h012_340F, 0, 0, 0, "R5");
  endtask

  task automatic t_wrap();
    set_base(34'h3_FFFF_FF00);
    xlate(48'hFFFF_FFFF_FFFF, 2'b00, 32'h0C0_FFE3, 0, 0, 0, "R2");
  endtask

  task automatic t_latency_hold();
    xlate(48'h0000_0ABC_D123, 2'b01, 32'h0BE_EF05, 20, 4, 0, "R8");
  endtask

  task automatic t_stray_strobe();
    mem_rd_valid = 1'b1; mem_rd_data = 32'h000_0013;
    @(negedge clk);
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R8", "stray strobe no response", 64'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R8", "stray strobe stays idle", 64'(req_ready), 1);
  endtask

  task automatic t_busy_pokes();
    set_base(34'h0_0004_0000);
    xlate(48'h0000_0002_0000, 2'b00, 32'h033_3333, 1, 0, 1, "R6");
    // base write during the walk must have been dropped (R9)
    xlate(48'h0000_0003_0000, 2'b00, 32'h044_4443, 0, 0, 0, "R9");
  endtask

  initial begin
    rst_n = 1'b0; base_we = 1'b0; base_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_kind = 2'b00;
    mem_rd_valid = 1'b0; mem_rd_data = '0; rsp_ready = 1'b0;
    base_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_grants();
    t_miss();
    t_deny();
    t_wrap();
    t_latency_hold();
    t_stray_strobe();
    t_busy_pokes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule